// File: doc/BRIEF.md
# I2C Master Transaction Sequencer

This block is the control engine of an I2C master. Software-style register inputs give it an address byte, a control word, a length word, an optional separate read length, a transaction count and a start word. Once a start word arrives, the block runs one or more bus transactions. It does this by handing single requests to a bit-level bus engine: START, repeated START, write byte, read byte with ACK, read byte with NACK, and STOP. Each request waits for the engine's done pulse. Write data is pulled from a byte-wide transmit stream, and read data is pushed out on a byte-wide receive stream.

Transactions come in several forms:
- A plain write or a plain read, with the direction taken from bit 0 of the address byte.
- A combined write-then-read: the write phase is followed by a repeated START and a read phase, using split write and read lengths.
- A counted series of transactions joined by repeated STARTs or by STOP/START pairs.
- A triggered multi-transaction mode. Here the bus is held after each transaction until software sends the next trigger.

A sticky write-one-to-clear status register records completion, ACK errors, lost arbitration and restart points. The interrupt output is that register gated by a mask register.

The controller is one enumerated state machine. Its states are:

| State | Role |
|---|---|
| IDLE | Waits for a start word. |
| START | Issues START or repeated START. |
| ADDR | Sends the address byte. |
| FETCH | Takes one byte from the transmit stream. |
| WRITE | Sends that byte. |
| TURN | Issues the repeated START for the direction change. |
| RADDR | Sends the address byte with the read bit set. |
| READ | Reads one byte. |
| ENDTX | Decides what follows a transaction. |
| STOP | Issues STOP. |
| FINISH | Raises completion. |
| HOLD | Keeps the bus and waits for a new trigger. |

Its transitions are:

| Transition | Condition |
|---|---|
| IDLE→START | Trigger. |
| START→ADDR | Done. |
| ADDR→FETCH / READ / TURN / ENDTX | Chosen by direction and length. |
| FETCH→WRITE | Byte taken. |
| WRITE→FETCH / TURN / ENDTX | Chosen by the bytes left. |
| TURN→RADDR | Done. |
| RADDR→READ / ENDTX | Chosen by the read length. |
| READ→READ / ENDTX | Chosen by the bytes left. |
| ENDTX→START / STOP / HOLD | Chosen by the mode and the count. |
| STOP→START / FINISH | Chosen by whether more transactions follow. |
| FINISH→IDLE | Always. |
| HOLD→START | New trigger. |
| ADDR / WRITE / RADDR→STOP | ACK error. |
| Any bus state→IDLE | Lost arbitration. |

Top module: `i2c_txn_seq`

## Requirements
- R1: After reset the status register reads 0, the mask register is 0, `irq` is 0 and no bus request is pending.
- R2: Status bits are: bit 0 transaction complete, bit 1 ACK error, bit 2 high-speed code NACK (never set by this block), bit 3 arbitration lost, bit 4 restart done. A bit stays set until a clear write with a 1 in that position; a clear write of 0 leaves it set.
- R3: `irq` is 1 exactly when some status bit and the same mask bit are both 1.
- R4: A start word with bit 0 set runs the transaction. The request codes are START=0, repeated START=1, write=2, read+ACK=3, read+NACK=4 and STOP=5. A write transaction is START, the address byte, then length (bits 7:0 of the length word) bytes from the transmit stream in order, then STOP, after which status bit 0 is set. The transaction is a write when address bit 0 is 0.
- R5: When address bit 0 is 1, the address is followed by length reads. Every read but the last uses read+ACK and the last uses read+NACK. Each byte read appears once on the receive stream, in order.
- R6: With control bit 4 set, one start word performs: START, the address with bit 0 cleared, the write-length bytes, repeated START, the address with bit 0 set, then the read-length reads and STOP. The write length is in bits 7:0 of the length word and the read length in bits 12:8; bits 15:13 are ignored.
- R7: With control bit 5 set, a missing ACK on any address or data write stops the transaction. No further bytes are sent, STOP follows, and status bit 1 is set in an earlier cycle than bit 0. With control bit 5 clear, a missing ACK has no effect on the sequence.
- R8: Outside the triggered mode, a transaction count N>1 runs N transactions. Between them the block uses a repeated START when control bit 1 is 1, or STOP then START when it is 0. A count of 0 acts as 1.
- R9: With start bit 14 set, the block works in triggered mode. If bit 15 of the last trigger is 1, the end of a transaction sets status bit 4 and the block keeps the bus idle with no request until the next trigger, which resumes with a repeated START. If bit 15 is 0, the transaction ends with STOP and completion.
- R10: A done response flagged as lost arbitration sets status bit 3 and returns the block to idle with no STOP and without setting bit 0.
- R11: A write with length 0 consists of START, the address byte and STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| addr_byte | input | 8 | 7-bit address shifted left, bit 0 = read |
| ctrl_word | input | 16 | Bit 1 restart between transactions, bit 4 direction change, bit 5 ACK-error detect |
| xfer_len | input | 16 | Write length [7:0]; packed read length [12:8] |
| aux_len | input | LEN_W | Read length when AUX_EN=1 |
| txn_count | input | CNT_W | Number of transactions |
| start_we | input | 1 | Start word write strobe |
| start_wd | input | 16 | Bit 0 go, bit 14 triggered mode, bit 15 restart next |
| stat_clr_we | input | 1 | Status clear strobe |
| stat_clr_wd | input | 5 | Ones clear the matching status bits |
| mask_we | input | 1 | Mask write strobe |
| mask_wd | input | 5 | New mask value |
| cmd_valid | output | 1 | Bus request pending, held until done |
| cmd_op | output | 3 | Request code |
| cmd_data | output | 8 | Byte for write requests |
| bus_done | input | 1 | Bus engine finished the request |
| bus_ack | input | 1 | Slave acknowledged the written byte |
| bus_arb_lost | input | 1 | Arbitration lost during the request |
| bus_rdata | input | 8 | Byte read |
| tx_valid | input | 1 | Transmit byte available |
| tx_data | input | 8 | Transmit byte |
| tx_ready | output | 1 | Transmit byte taken this cycle |
| rx_valid | output | 1 | Receive byte valid (one cycle) |
| rx_data | output | 8 | Receive byte |
| irq_stat | output | 5 | Status register |
| irq | output | 1 | Interrupt |

## Verification
The bench uses the default parameters: 8-bit lengths and counts, the packed length word (AUX_EN=0) and a 5-bit read-length field. This makes the packed field decoding reachable, including a length word whose bit 13 is set and must be ignored. The bus engine model answers every request after a fixed delay, and it can withhold the ACK or report lost arbitration on any chosen request. This lets the error-ordering, ignored-NACK and abandon paths be reached from any phase. The separate read-length input is not exercised at these settings.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

    typedef enum logic [2:0] {
        OP_START   = 3'd0,
        OP_RSTART  = 3'd1,
        OP_WRITE   = 3'd2,
        OP_RD_ACK  = 3'd3,
        OP_RD_NACK = 3'd4,
        OP_STOP    = 3'd5
    } bus_op_e;

    typedef enum logic [3:0] {
        S_IDLE, S_START, S_ADDR, S_FETCH, S_WRITE, S_TURN,
        S_RADDR, S_READ, S_ENDTX, S_STOP, S_FINISH, S_HOLD
    } seq_state_e;

    localparam int ST_CMPL   = 0;
    localparam int ST_ACKERR = 1;
    localparam int ST_HSNACK = 2;
    localparam int ST_ARB    = 3;
    localparam int ST_RSDONE = 4;
    localparam int ST_NB     = 5;

    localparam int CTL_RS     = 1;
    localparam int CTL_DIRCHG = 4;
    localparam int CTL_ACKDET = 5;

    localparam int GO_BIT     = 0;
    localparam int MULTI_BIT  = 14;
    localparam int RSNEXT_BIT = 15;

endpackage

// File: rtl/i2cs_len_sel.sv
module i2cs_len_sel #(
    parameter int LEN_W   = 8,
    parameter int PK_RD_W = 5,
    parameter bit AUX_EN  = 1'b0
) (
    input  logic [15:0]      xfer_len,
    input  logic [LEN_W-1:0] aux_len,
    output logic [LEN_W-1:0] wr_len,
    output logic [LEN_W-1:0] rd_len
);
    localparam int PK_LO = 8;
    localparam int PK_HI = PK_LO + PK_RD_W;

    assign wr_len = xfer_len[LEN_W-1:0];

    generate
        if (AUX_EN) begin : g_aux
            logic unused_pk;
            assign unused_pk = ^xfer_len[15:LEN_W];
            assign rd_len    = aux_len;
        end else begin : g_pk
            logic unused_aux;
            assign unused_aux = ^{aux_len, xfer_len[15:PK_HI]};
            assign rd_len     = LEN_W'(xfer_len[PK_HI-1:PK_LO]);
        end
    endgenerate

endmodule

// File: rtl/i2cs_irq_regs.sv
module i2cs_irq_regs #(
    parameter int NB = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NB-1:0] set_evt,
    input  logic          clr_we,
    input  logic [NB-1:0] clr_wd,
    input  logic          mask_we,
    input  logic [NB-1:0] mask_wd,
    output logic [NB-1:0] stat,
    output logic          irq
);
    logic [NB-1:0] mask_q;
    logic [NB-1:0] clr_eff;

    assign clr_eff = clr_we ? clr_wd : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat   <= '0;
            mask_q <= '0;
        end else begin
            stat <= (stat & ~clr_eff) | set_evt;
            if (mask_we) mask_q <= mask_wd;
        end
    end

    assign irq = |(stat & mask_q);

    // R2: a cleared bit is low after the write unless a new event set it
    a_r2_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> ((stat & $past(clr_wd) & ~$past(set_evt)) == '0));

    // R2: a set bit is never lost without a clear write
    a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(stat) & ~($past(clr_we) ? $past(clr_wd) : '0)) & ~stat) == '0));

endmodule

// File: rtl/i2cs_fsm.sv
module i2cs_fsm
    import i2cs_pkg::*;
#(
    parameter int LEN_W = 8,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       addr_byte,
    input  logic [15:0]      ctrl_word,
    input  logic [LEN_W-1:0] wr_len,
    input  logic [LEN_W-1:0] rd_len,
    input  logic [CNT_W-1:0] txn_count,
    input  logic             start_we,
    input  logic [15:0]      start_wd,
    output logic             cmd_valid,
    output bus_op_e          cmd_op,
    output logic [7:0]       cmd_data,
    input  logic             bus_done,
    input  logic             bus_ack,
    input  logic             bus_arb_lost,
    input  logic [7:0]       bus_rdata,
    input  logic             tx_valid,
    input  logic [7:0]       tx_data,
    output logic             tx_ready,
    output logic             rx_valid,
    output logic [7:0]       rx_data,
    output logic [ST_NB-1:0] evt
);
    seq_state_e state, nxt;

    logic [7:0]       addr_q;
    logic [7:0]       byte_q;
    logic [LEN_W-1:0] wlen_q, rlen_q, left_q;
    logic [CNT_W-1:0] txn_left;
    logic             wrrd_q, ackdet_q, rs_q, multi_q, rsnext_q;
    logic             rstart_q, cont_q;
    logic             rx_valid_q;
    logic [7:0]       rx_data_q;

    logic trig, done_ok, lost, wr_state, bus_state, nack_err, rd_dir, more_txn;
    logic unused_ctl;

    assign unused_ctl = ^{ctrl_word[15:6], ctrl_word[3:2], ctrl_word[0], start_wd[13:1]};

    assign trig      = start_we && start_wd[GO_BIT];
    assign done_ok   = bus_done && !bus_arb_lost;
    assign lost      = bus_done && bus_arb_lost;
    assign wr_state  = (state == S_ADDR) || (state == S_WRITE) || (state == S_RADDR);
    assign bus_state = wr_state || (state == S_START) || (state == S_TURN) || (state == S_READ);
    assign nack_err  = wr_state && done_ok && !bus_ack && ackdet_q;
    assign rd_dir    = !wrrd_q && addr_q[0];
    assign more_txn  = !multi_q && (txn_left > CNT_W'(1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:   if (trig) nxt = S_START;
            S_START:  if (lost) nxt = S_IDLE;
                      else if (bus_done) nxt = S_ADDR;
            S_ADDR: begin
                if (lost) nxt = S_IDLE;
                else if (nack_err) nxt = S_STOP;
                else if (bus_done) begin
                    if (rd_dir) nxt = (wlen_q == '0) ? S_ENDTX : S_READ;
                    else if (wlen_q == '0) nxt = wrrd_q ? S_TURN : S_ENDTX;
                    else nxt = S_FETCH;
                end
            end
            S_FETCH:  if (tx_valid) nxt = S_WRITE;
            S_WRITE: begin
                if (lost) nxt = S_IDLE;
                else if (nack_err) nxt = S_STOP;
                else if (bus_done) begin
                    if (left_q == LEN_W'(1)) nxt = wrrd_q ? S_TURN : S_ENDTX;
                    else nxt = S_FETCH;
                end
            end
            S_TURN:   if (lost) nxt = S_IDLE;
                      else if (bus_done) nxt = S_RADDR;
            S_RADDR: begin
                if (lost) nxt = S_IDLE;
                else if (nack_err) nxt = S_STOP;
                else if (bus_done) nxt = (rlen_q == '0) ? S_ENDTX : S_READ;
            end
            S_READ: begin
                if (lost) nxt = S_IDLE;
                else if (bus_done) nxt = (left_q == LEN_W'(1)) ? S_ENDTX : S_READ;
            end
            S_ENDTX: begin
                if (multi_q) nxt = rsnext_q ? S_HOLD : S_STOP;
                else if (more_txn && rs_q) nxt = S_START;
                else nxt = S_STOP;
            end
            S_STOP:   if (bus_done) nxt = cont_q ? S_START : S_FINISH;
            S_FINISH: nxt = S_IDLE;
            S_HOLD:   if (trig) nxt = S_START;
            default:  nxt = S_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q     <= '0;
            byte_q     <= '0;
            wlen_q     <= '0;
            rlen_q     <= '0;
            left_q     <= '0;
            txn_left   <= '0;
            wrrd_q     <= 1'b0;
            ackdet_q   <= 1'b0;
            rs_q       <= 1'b0;
            multi_q    <= 1'b0;
            rsnext_q   <= 1'b0;
            rstart_q   <= 1'b0;
            cont_q     <= 1'b0;
            rx_valid_q <= 1'b0;
            rx_data_q  <= '0;
        end else begin
            rx_valid_q <= (state == S_READ) && done_ok;
            if ((state == S_READ) && done_ok) rx_data_q <= bus_rdata;
            unique case (state)
                S_IDLE: if (trig) begin
                    addr_q   <= addr_byte;
                    wrrd_q   <= ctrl_word[CTL_DIRCHG];
                    ackdet_q <= ctrl_word[CTL_ACKDET];
                    rs_q     <= ctrl_word[CTL_RS];
                    multi_q  <= start_wd[MULTI_BIT];
                    rsnext_q <= start_wd[RSNEXT_BIT];
                    wlen_q   <= wr_len;
                    rlen_q   <= rd_len;
                    rstart_q <= 1'b0;
                    cont_q   <= 1'b0;
                    if (ctrl_word[CTL_DIRCHG] || txn_count == '0) txn_left <= CNT_W'(1);
                    else txn_left <= txn_count;
                end
                S_START: if (bus_done) rstart_q <= 1'b0;
                S_ADDR:  if (done_ok) left_q <= wlen_q;
                S_FETCH: if (tx_valid) byte_q <= tx_data;
                S_WRITE: if (done_ok) left_q <= left_q - LEN_W'(1);
                S_RADDR: if (done_ok) left_q <= rlen_q;
                S_READ:  if (done_ok) left_q <= left_q - LEN_W'(1);
                S_ENDTX: if (more_txn) begin
                    txn_left <= txn_left - CNT_W'(1);
                    rstart_q <= rs_q;
                    cont_q   <= !rs_q;
                end
                S_STOP:  if (bus_done) cont_q <= 1'b0;
                S_HOLD:  if (trig) begin
                    rsnext_q <= start_wd[RSNEXT_BIT];
                    rstart_q <= 1'b1;
                end
                default: ;
            endcase
            if (nack_err) cont_q <= 1'b0;
        end
    end

    // outputs
    always_comb begin
        cmd_valid = 1'b0;
        cmd_op    = OP_STOP;
        cmd_data  = 8'h00;
        tx_ready  = 1'b0;
        unique case (state)
            S_START: begin
                cmd_valid = 1'b1;
                cmd_op    = rstart_q ? OP_RSTART : OP_START;
            end
            S_ADDR: begin
                cmd_valid = 1'b1;
                cmd_op    = OP_WRITE;
                cmd_data  = wrrd_q ? {addr_q[7:1], 1'b0} : addr_q;
            end
            S_FETCH: tx_ready = 1'b1;
            S_WRITE: begin
                cmd_valid = 1'b1;
                cmd_op    = OP_WRITE;
                cmd_data  = byte_q;
            end
            S_TURN: begin
                cmd_valid = 1'b1;
                cmd_op    = OP_RSTART;
            end
            S_RADDR: begin
                cmd_valid = 1'b1;
                cmd_op    = OP_WRITE;
                cmd_data  = {addr_q[7:1], 1'b1};
            end
            S_READ: begin
                cmd_valid = 1'b1;
                cmd_op    = (left_q == LEN_W'(1)) ? OP_RD_NACK : OP_RD_ACK;
            end
            S_STOP: begin
                cmd_valid = 1'b1;
                cmd_op    = OP_STOP;
            end
            default: ;
        endcase
    end

    always_comb begin
        evt            = '0;
        evt[ST_CMPL]   = (state == S_FINISH);
        evt[ST_ACKERR] = nack_err;
        evt[ST_HSNACK] = 1'b0;
        evt[ST_ARB]    = bus_state && lost;
        evt[ST_RSDONE] = (state == S_ENDTX) && multi_q && rsnext_q;
    end

    assign rx_valid = rx_valid_q;
    assign rx_data  = rx_data_q;

    // R4: a request and its byte stay put until the engine reports done
    a_r4_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !bus_done) |=> (cmd_valid && $stable(cmd_op) && $stable(cmd_data)));

    // R7: an ACK error is followed directly by a STOP request
    a_r7_err_then_stop: assert property (@(posedge clk) disable iff (!rst_n)
        evt[ST_ACKERR] |=> (cmd_valid && cmd_op == OP_STOP));

    // R10: lost arbitration leaves the bus with no further request
    a_r10_arb_idle: assert property (@(posedge clk) disable iff (!rst_n)
        evt[ST_ARB] |=> !cmd_valid);

    // R5: received bytes only follow a read request
    a_r5_rx_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(cmd_op == OP_RD_ACK || cmd_op == OP_RD_NACK));

endmodule

// File: rtl/i2c_txn_seq.sv
module i2c_txn_seq
    import i2cs_pkg::*;
#(
    parameter int LEN_W   = 8,
    parameter int CNT_W   = 8,
    parameter int PK_RD_W = 5,
    parameter bit AUX_EN  = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       addr_byte,
    input  logic [15:0]      ctrl_word,
    input  logic [15:0]      xfer_len,
    input  logic [LEN_W-1:0] aux_len,
    input  logic [CNT_W-1:0] txn_count,
    input  logic             start_we,
    input  logic [15:0]      start_wd,
    input  logic             stat_clr_we,
    input  logic [4:0]       stat_clr_wd,
    input  logic             mask_we,
    input  logic [4:0]       mask_wd,
    output logic             cmd_valid,
    output logic [2:0]       cmd_op,
    output logic [7:0]       cmd_data,
    input  logic             bus_done,
    input  logic             bus_ack,
    input  logic             bus_arb_lost,
    input  logic [7:0]       bus_rdata,
    input  logic             tx_valid,
    input  logic [7:0]       tx_data,
    output logic             tx_ready,
    output logic             rx_valid,
    output logic [7:0]       rx_data,
    output logic [4:0]       irq_stat,
    output logic             irq
);
    logic [LEN_W-1:0] wr_len, rd_len;
    logic [ST_NB-1:0] evt;
    bus_op_e          op_e;

    i2cs_len_sel #(.LEN_W(LEN_W), .PK_RD_W(PK_RD_W), .AUX_EN(AUX_EN)) u_len (
        .xfer_len (xfer_len),
        .aux_len  (aux_len),
        .wr_len   (wr_len),
        .rd_len   (rd_len)
    );

    i2cs_fsm #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .addr_byte    (addr_byte),
        .ctrl_word    (ctrl_word),
        .wr_len       (wr_len),
        .rd_len       (rd_len),
        .txn_count    (txn_count),
        .start_we     (start_we),
        .start_wd     (start_wd),
        .cmd_valid    (cmd_valid),
        .cmd_op       (op_e),
        .cmd_data     (cmd_data),
        .bus_done     (bus_done),
        .bus_ack      (bus_ack),
        .bus_arb_lost (bus_arb_lost),
        .bus_rdata    (bus_rdata),
        .tx_valid     (tx_valid),
        .tx_data      (tx_data),
        .tx_ready     (tx_ready),
        .rx_valid     (rx_valid),
        .rx_data      (rx_data),
        .evt          (evt)
    );

    assign cmd_op = op_e;

    i2cs_irq_regs #(.NB(ST_NB)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_evt (evt),
        .clr_we  (stat_clr_we),
        .clr_wd  (stat_clr_wd),
        .mask_we (mask_we),
        .mask_wd (mask_wd),
        .stat    (irq_stat),
        .irq     (irq)
    );

endmodule

// File: tb/sim_i2c_txn_seq.sv
module sim_i2c_txn_seq;
    localparam int CLK_PERIOD = 10;
    localparam logic [2:0] C_ST = 3'd0, C_RS = 3'd1, C_WR = 3'd2,
                           C_RA = 3'd3, C_RN = 3'd4, C_SP = 3'd5;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [7:0] addr_byte = '0;
    logic [15:0] ctrl_word = '0, xfer_len = '0, start_wd = '0;
    logic [7:0] aux_len = '0, txn_count = '0;
    logic start_we = 1'b0, stat_clr_we = 1'b0, mask_we = 1'b0;
    logic [4:0] stat_clr_wd = '0, mask_wd = '0;
    logic cmd_valid, tx_ready, rx_valid, irq;
    logic [2:0] cmd_op;
    logic [7:0] cmd_data, rx_data, tx_data;
    logic bus_done = 1'b0, bus_ack = 1'b1, bus_arb_lost = 1'b0;
    logic [7:0] bus_rdata = '0;
    logic tx_valid = 1'b1;
    logic [4:0] irq_stat;

    int checks = 0, errors = 0;
    int eng_cnt = 0, cmd_idx = 0, rd_idx = 0, nack_at = -1, arb_at = -1;
    int cyc = 0, t_ack = -1, t_cmp = -1;
    int tx_idx = 0, tx_next = 0;
    bit finished = 0;
    logic [10:0] exp_q[$];
    logic [7:0]  exp_rx[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_txn_seq u0 (
        .clk(clk), .rst_n(rst_n), .addr_byte(addr_byte), .ctrl_word(ctrl_word),
        .xfer_len(xfer_len), .aux_len(aux_len), .txn_count(txn_count),
        .start_we(start_we), .start_wd(start_wd), .stat_clr_we(stat_clr_we),
        .stat_clr_wd(stat_clr_wd), .mask_we(mask_we), .mask_wd(mask_wd),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_data(cmd_data),
        .bus_done(bus_done), .bus_ack(bus_ack), .bus_arb_lost(bus_arb_lost),
        .bus_rdata(bus_rdata), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_data(rx_data),
        .irq_stat(irq_stat), .irq(irq)
    );

    assign tx_data = 8'h30 + 8'(tx_idx);
    always @(posedge clk) if (tx_ready && tx_valid) tx_idx <= tx_idx + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    task automatic push(input logic [2:0] op, input logic [7:0] d);
        exp_q.push_back({op, d});
    endtask

    task automatic push_wr_data(input int n);
        for (int i = 0; i < n; i++) begin
            push(C_WR, 8'h30 + 8'(tx_next));
            tx_next++;
        end
    endtask

    task automatic push_reads(input int n);
        for (int i = 0; i < n; i++) begin
            push((i == n - 1) ? C_RN : C_RA, 8'h00);
            exp_rx.push_back(8'hA0 + 8'(i));
        end
    endtask

    // monitor: engine model plus scoreboard
    always @(negedge clk) begin
        cyc++;
        if (!rst_n) begin
            bus_done = 1'b0;
            eng_cnt = 0;
        end else if (bus_done) begin
            bus_done = 1'b0;
            bus_arb_lost = 1'b0;
            eng_cnt = 0;
        end else if (cmd_valid) begin
            eng_cnt++;
            if (eng_cnt == 2) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R4", "unexpected request", int'(cmd_op), -1);
                end else begin
                    logic [10:0] e;
                    e = exp_q.pop_front();
                    chk(e[10:8] == cmd_op && (cmd_op != C_WR || e[7:0] == cmd_data),
                        "R4", "request op/data", int'({cmd_op, cmd_data}), int'(e));
                end
                bus_ack = (cmd_idx != nack_at);
                bus_arb_lost = (cmd_idx == arb_at);
                bus_rdata = 8'hA0 + 8'(rd_idx);
                if (cmd_op == C_RA || cmd_op == C_RN) rd_idx++;
                cmd_idx++;
                bus_done = 1'b1;
            end
        end
        if (rst_n && rx_valid) begin
            if (exp_rx.size() == 0) chk(0, "R5", "unexpected rx byte", int'(rx_data), -1);
            else begin
                logic [7:0] r;
                r = exp_rx.pop_front();
                chk(rx_data == r, "R5", "rx byte", int'(rx_data), int'(r));
            end
        end
        if (rst_n && irq_stat[1] && t_ack < 0) t_ack = cyc;
        if (rst_n && irq_stat[0] && t_cmp < 0) t_cmp = cyc;
    end

    task automatic setup(input logic [7:0] a, input logic [15:0] c,
                         input logic [15:0] l, input logic [7:0] n);
        @(negedge clk);
        addr_byte = a; ctrl_word = c; xfer_len = l; txn_count = n;
        cmd_idx = 0; rd_idx = 0; nack_at = -1; arb_at = -1;
        t_ack = -1; t_cmp = -1;
    endtask

    task automatic trigger(input logic [15:0] w);
        @(negedge clk); start_we = 1'b1; start_wd = w;
        @(negedge clk); start_we = 1'b0; start_wd = '0;
    endtask

    task automatic clear_stat(input logic [4:0] m);
        @(negedge clk); stat_clr_we = 1'b1; stat_clr_wd = m;
        @(negedge clk); stat_clr_we = 1'b0; stat_clr_wd = '0;
    endtask

    task automatic set_mask(input logic [4:0] m);
        @(negedge clk); mask_we = 1'b1; mask_wd = m;
        @(negedge clk); mask_we = 1'b0;
    endtask

    task automatic wait_flag(input int b);
        for (int i = 0; i < 3000 && !irq_stat[b]; i++) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic queues_empty(input string req);
        chk(exp_q.size() == 0, req, "requests left", exp_q.size(), 0);
        chk(exp_rx.size() == 0, req, "rx bytes left", exp_rx.size(), 0);
        chk(tx_idx == tx_next, req, "tx bytes taken", tx_idx, tx_next);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(irq_stat == 5'h00, "R1", "status after reset", irq_stat, 0);
        chk(irq == 1'b0, "R1", "irq after reset", irq, 0);
        chk(cmd_valid == 1'b0, "R1", "no request after reset", cmd_valid, 0);
        set_mask(5'h1F);

        // R4: plain write of 3 bytes
        setup(8'hA0, 16'h0020, 16'h0003, 8'd1);
        push(C_ST, 0); push(C_WR, 8'hA0); push_wr_data(3); push(C_SP, 0);
        trigger(16'h0001);
        wait_flag(0);
        queues_empty("R4");
        chk(irq_stat == 5'h01, "R4", "complete status", irq_stat, 1);
        chk(irq == 1'b1, "R3", "irq with mask set", irq, 1);
        // R2: clear write of 0 leaves bit, clear of 1 removes it
        clear_stat(5'h00);
        chk(irq_stat == 5'h01, "R2", "zero clear ignored", irq_stat, 1);
        clear_stat(5'h01);
        chk(irq_stat == 5'h00, "R2", "w1c", irq_stat, 0);
        chk(irq == 1'b0, "R3", "irq after clear", irq, 0);

        // R11: zero-length write, with completion masked (R3)
        set_mask(5'h1E);
        setup(8'hA0, 16'h0020, 16'h0000, 8'd1);
        push(C_ST, 0); push(C_WR, 8'hA0); push(C_SP, 0);
        trigger(16'h0001);
        wait_flag(0);
        queues_empty("R11");
        chk(irq_stat == 5'h01, "R11", "complete status", irq_stat, 1);
        chk(irq == 1'b0, "R3", "irq masked", irq, 0);
        set_mask(5'h1F);
        chk(irq == 1'b1, "R3", "irq unmasked", irq, 1);
        clear_stat(5'h1F);

        // R5: read of 3 bytes
        setup(8'hA1, 16'h0020, 16'h0003, 8'd1);
        push(C_ST, 0); push(C_WR, 8'hA1); push_reads(3); push(C_SP, 0);
        trigger(16'h0001);
        wait_flag(0);
        queues_empty("R5");
        chk(irq_stat == 5'h01, "R5", "complete status", irq_stat, 1);
        clear_stat(5'h1F);

        // R6: write 2 then read 2; bit 13 of length ignored
        setup(8'hA0, 16'h0030, 16'h2202, 8'd7);
        push(C_ST, 0); push(C_WR, 8'hA0); push_wr_data(2);
        push(C_RS, 0); push(C_WR, 8'hA1); push_reads(2); push(C_SP, 0);
        trigger(16'h0001);
        wait_flag(0);
        queues_empty("R6");
        chk(irq_stat == 5'h01, "R6", "complete status", irq_stat, 1);
        clear_stat(5'h1F);

        // R7: ACK error on second data byte
        setup(8'hA0, 16'h0020, 16'h0004, 8'd1);
        nack_at = 3;
        push(C_ST, 0); push(C_WR, 8'hA0); push_wr_data(2); push(C_SP, 0);
        trigger(16'h0001);
        wait_flag(0);
        queues_empty("R7");
        chk(irq_stat == 5'h03, "R7", "error+complete status", irq_stat, 3);
        chk(t_ack >= 0 && t_ack < t_cmp, "R7", "error before complete", t_ack, t_cmp);
        clear_stat(5'h1F);

        // R7: NACK ignored when detection off
        setup(8'hA0, 16'h0000, 16'h0002, 8'd1);
        nack_at = 2;
        push(C_ST, 0); push(C_WR, 8'hA0); push_wr_data(2); push(C_SP, 0);
        trigger(16'h0001);
        wait_flag(0);
        queues_empty("R7");
        chk(irq_stat == 5'h01, "R7", "nack ignored status", irq_stat, 1);
        clear_stat(5'h1F);

        // R8: two transactions joined by repeated START
        setup(8'hA0, 16'h0022, 16'h0001, 8'd2);
        push(C_ST, 0); push(C_WR, 8'hA0); push_wr_data(1);
        push(C_RS, 0); push(C_WR, 8'hA0); push_wr_data(1); push(C_SP, 0);
        trigger(16'h0001);
        wait_flag(0);
        queues_empty("R8");
        chk(irq_stat == 5'h01, "R8", "complete status rs", irq_stat, 1);
        clear_stat(5'h1F);

        // R8: two transactions joined by STOP/START
        setup(8'hA0, 16'h0020, 16'h0001, 8'd2);
        push(C_ST, 0); push(C_WR, 8'hA0); push_wr_data(1); push(C_SP, 0);
        push(C_ST, 0); push(C_WR, 8'hA0); push_wr_data(1); push(C_SP, 0);
        trigger(16'h0001);
        wait_flag(0);
        queues_empty("R8");
        chk(irq_stat == 5'h01, "R8", "complete status stop", irq_stat, 1);
        clear_stat(5'h1F);

        // R9: triggered mode with a held bus
        setup(8'hA0, 16'h0020, 16'h0001, 8'd5);
        push(C_ST, 0); push(C_WR, 8'hA0); push_wr_data(1);
        trigger(16'hC001);
        wait_flag(4);
        queues_empty("R9");
        chk(irq_stat == 5'h10, "R9", "restart done only", irq_stat, 5'h10);
        repeat (10) @(negedge clk);
        chk(cmd_valid == 1'b0, "R9", "bus held idle", cmd_valid, 0);
        push(C_RS, 0); push(C_WR, 8'hA0); push_wr_data(1); push(C_SP, 0);
        trigger(16'h4001);
        wait_flag(0);
        queues_empty("R9");
        chk(irq_stat == 5'h11, "R9", "restart+complete", irq_stat, 5'h11);
        clear_stat(5'h1F);

        // R10: arbitration lost on the address byte
        setup(8'hA0, 16'h0020, 16'h0002, 8'd1);
        arb_at = 1;
        push(C_ST, 0); push(C_WR, 8'hA0);
        trigger(16'h0001);
        wait_flag(3);
        repeat (10) @(negedge clk);
        queues_empty("R10");
        chk(irq_stat == 5'h08, "R10", "arb status no complete", irq_stat, 8);
        chk(cmd_valid == 1'b0, "R10", "idle after arb loss", cmd_valid, 0);

        if (!finished) begin
            finished = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog: run hung act=0 exp=1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule